// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the software-visible face of an MD5 / SHA-1 compression engine. A simple word-addressed register port gives access to a control register, five seed registers, a 32-word input queue with a free-space status register, and the digest words. On the other side a block-level port drives a compression core. Through it the front-end loads the core's chaining state, hands it 16-word message blocks, and collects the updated state when the core signals done.

Software enables the engine with a chosen mode. The chaining state starts from the standard constants, or from the seed registers when resuming an earlier computation. Software then streams words into the queue. Whenever the core is idle and at least 16 words are waiting, the oldest 16 go to the core as one block. To finish, software sets the data-end bit and polls it until it reads 0, then reads the digest. The engine never holds a partial block. The state is meaningful only at 64-byte boundaries, and words short of a full block are discarded when the data-end request completes. Writing 0 to the control register shuts the engine down and wipes its contents.

The control state machine has three states. `ST_OFF` goes to `ST_READY` when the enable bit is written as 1. `ST_READY` goes to `ST_BUSY` when a block is pushed. `ST_BUSY` returns to `ST_READY` on core done. Any state goes to `ST_OFF` when the enable bit is written as 0.

Top module: `hash_regfront`

## Requirements
- R1: Register address 0 is the control register: bit 0 enable, bit 1 mode (0 = MD5, 1 = SHA-1), bit 2 seed-from-registers, bit 3 data-end; it reads back those four bits. While enabled, a write with bit 0 set changes no field except that a 1 in bit 3 sets data-end.
- R2: On the write that enables a disabled engine, the chaining state (loaded into the core with a one-cycle `core_load` pulse, and visible at the digest addresses) becomes the words at addresses 2..6 if bit 2 is set. Otherwise it becomes the standard constants: 67452301, EFCDAB89, 98BADCFE, 10325476 for word 0 to word 3, plus C3D2E1F0 as word 4 in SHA-1 mode.
- R3: Writes to address 7 enqueue a word; address 1 bits [5:0] give the number of free queue slots, which is 32 right after each enable.
- R4: When the engine is ready and at least 16 words are queued, the 16 oldest words go to the core as one block (oldest word in `core_block[31:0]`) with a one-cycle `core_push`; the state returned with `core_done` becomes the new chaining state.
- R5: Addresses 8..12 read chaining-state words 0..4; in MD5 mode address 12 reads 0.
- R6: Data-end reads back 1 until the engine is ready with fewer than 16 words queued, then clears by itself and discards the leftover words (free count back to 32).
- R7: A queue write while 32 words are queued is dropped and sets status bit 8, which stays set until the engine is disabled or re-enabled.
- R8: Writing the control register with bit 0 clear disables the engine: control reads 0, digest words read 0, the queue empties and the overflow bit clears; queue writes while disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from the address) |
| core_load | output | 1 | Load `core_init` into the core |
| core_sha1 | output | 1 | Core mode, 1 = SHA-1 |
| core_init | output | 160 | Seed chaining state |
| core_push | output | 1 | Block valid for the core |
| core_block | output | 512 | 16 message words, oldest in bits 31:0 |
| core_done | input | 1 | Core has finished the pushed block |
| core_state | input | 160 | Core chaining state after the block |

## Verification
Read data is combinational, so a register written at a clock edge is read back at the following falling edge. The bench reads control, status and seed digest one cycle after each write. A block push happens on the edge after the 16th queued word, so the free count is sampled two cycles after that word. The chaining state follows `core_done` by one edge and depends on the latency of the stub core, which the bench varies. For that reason the bench never waits a fixed time for digests: it polls the data-end bit (R6) and reads the digest only after the bit reads 0.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

    typedef enum logic [1:0] {ST_OFF, ST_READY, ST_BUSY} fsm_t;

    localparam int CB_EN  = 0;
    localparam int CB_SHA = 1;
    localparam int CB_IVA = 2;
    localparam int CB_END = 3;

    localparam logic [3:0] A_CTL  = 4'd0;
    localparam logic [3:0] A_STAT = 4'd1;
    localparam logic [3:0] A_IV0  = 4'd2;
    localparam logic [3:0] A_IV4  = 4'd6;
    localparam logic [3:0] A_FIFO = 4'd7;
    localparam logic [3:0] A_DG0  = 4'd8;
    localparam logic [3:0] A_DG4  = 4'd12;

    function automatic logic [159:0] std_seed(input logic sha);
        std_seed = {(sha ? 32'hC3D2E1F0 : 32'h0), 32'h10325476,
                    32'h98BADCFE, 32'hEFCDAB89, 32'h67452301};
    endfunction

endpackage

// File: rtl/hrf_fifo.sv
module hrf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    parameter int BLK   = 16,
    localparam int NB   = DEPTH / BLK,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = (NB > 1) ? $clog2(NB) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             ovf_clr,
    input  logic             wr,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [CW-1:0]    count,
    output logic             ovf,
    output logic [BLK*W-1:0] blk_out
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [BW-1:0] rb;
    logic          wr_ok;

    assign wr_ok = wr && (count != CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (wr_ok && !flush) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rb    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (flush) begin
                wp    <= '0;
                rb    <= '0;
                count <= '0;
            end else begin
                wp    <= wp + AW'(wr_ok);
                rb    <= rb + BW'(pop);
                count <= count + CW'(wr_ok) - (pop ? CW'(BLK) : CW'(0));
            end
            if (ovf_clr)               ovf <= 1'b0;
            else if (wr && !wr_ok)     ovf <= 1'b1;
        end
    end

    for (genvar j = 0; j < BLK; j++) begin : g_word
        logic [AW-1:0] ix;
        assign ix = AW'(int'(rb) * BLK + j);
        assign blk_out[j*W +: W] = mem[ix];
    end

    AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
    AST_POP_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count >= CW'(BLK)); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && count == CW'(DEPTH) && !pop && !flush && !ovf_clr) |=> (count == CW'(DEPTH) && ovf)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf); // R7

endmodule

// File: rtl/hrf_ctrl.sv
module hrf_ctrl
    import hrf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int BLK   = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [3:0]    ctl_data,
    input  logic [CW-1:0] fifo_count,
    input  logic          core_done,
    output fsm_t          state,
    output logic          sha,
    output logic          iva,
    output logic          dend,
    output logic          start,
    output logic          stop,
    output logic          pop,
    output logic          fifo_flush,
    output logic          ovf_clr,
    output logic          core_load
);

    fsm_t nxt;
    logic end_clear;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   if (start)     nxt = ST_READY;
            ST_READY: if (pop)       nxt = ST_BUSY;
            ST_BUSY:  if (core_done) nxt = ST_READY;
            default:                 nxt = ST_OFF;
        endcase
        if (stop) nxt = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        start      = ctl_wr && ctl_data[CB_EN] && (state == ST_OFF);
        stop       = ctl_wr && !ctl_data[CB_EN];
        pop        = (state == ST_READY) && (fifo_count >= CW'(BLK)) && !stop;
        end_clear  = (state == ST_READY) && dend && (fifo_count < CW'(BLK)) && !stop;
        fifo_flush = stop || start || end_clear;
        ovf_clr    = stop || start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sha       <= 1'b0;
            iva       <= 1'b0;
            dend      <= 1'b0;
            core_load <= 1'b0;
        end else begin
            core_load <= start;
            if (stop) begin
                sha  <= 1'b0;
                iva  <= 1'b0;
                dend <= 1'b0;
            end else if (start) begin
                sha  <= ctl_data[CB_SHA];
                iva  <= ctl_data[CB_IVA];
                dend <= ctl_data[CB_END];
            end else begin
                if (end_clear) dend <= 1'b0;
                if (ctl_wr && ctl_data[CB_END] && state != ST_OFF) dend <= 1'b1;
            end
        end
    end

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_load |=> !core_load); // R2
    AST_PUSH_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> state == ST_BUSY); // R4
    AST_END_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (dend && state == ST_BUSY && !stop) |=> dend); // R6
    AST_END_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dend) && state != ST_OFF) |-> fifo_count == '0); // R6
    AST_OFF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (!dend && !sha && !iva)); // R8

endmodule

// File: rtl/hash_regfront.sv
module hash_regfront
    import hrf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int BLK   = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BLKW = BLK * 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [3:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            core_load,
    output logic            core_sha1,
    output logic [159:0]    core_init,
    output logic            core_push,
    output logic [BLKW-1:0] core_block,
    input  logic            core_done,
    input  logic [159:0]    core_state
);

    fsm_t          state;
    logic          sha, iva, dend, start, stop, pop, fifo_flush, ovf_clr, ovf;
    logic [CW-1:0] count;
    logic [31:0]   iv_q [5];
    logic [159:0]  iv_vec, dig_q;
    logic          ctl_wr, fifo_wr;

    assign ctl_wr  = bus_we && (bus_addr == A_CTL);
    assign fifo_wr = bus_we && (bus_addr == A_FIFO) && (state != ST_OFF);
    assign iv_vec  = {iv_q[4], iv_q[3], iv_q[2], iv_q[1], iv_q[0]};

    hrf_ctrl #(.DEPTH(DEPTH), .BLK(BLK)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(bus_wdata[3:0]),
        .fifo_count(count), .core_done(core_done), .state(state), .sha(sha),
        .iva(iva), .dend(dend), .start(start), .stop(stop), .pop(pop),
        .fifo_flush(fifo_flush), .ovf_clr(ovf_clr), .core_load(core_load)
    );

    hrf_fifo #(.W(32), .DEPTH(DEPTH), .BLK(BLK)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .ovf_clr(ovf_clr),
        .wr(fifo_wr), .wdata(bus_wdata), .pop(pop), .count(count), .ovf(ovf),
        .blk_out(core_block)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) iv_q[i] <= '0;
        end else if (bus_we && bus_addr >= A_IV0 && bus_addr <= A_IV4) begin
            iv_q[3'(bus_addr - A_IV0)] <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dig_q     <= '0;
            core_init <= '0;
        end else if (stop) begin
            dig_q     <= '0;
        end else if (start) begin
            dig_q     <= bus_wdata[CB_IVA] ? iv_vec : std_seed(bus_wdata[CB_SHA]);
            core_init <= bus_wdata[CB_IVA] ? iv_vec : std_seed(bus_wdata[CB_SHA]);
        end else if (core_done && state == ST_BUSY) begin
            dig_q     <= core_state;
        end
    end

    assign core_push = pop;
    assign core_sha1 = sha;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTL) begin
            bus_rdata = {28'd0, dend, iva, sha, (state != ST_OFF)};
        end else if (bus_addr == A_STAT) begin
            bus_rdata = (32'(ovf) << 8) | 32'(CW'(DEPTH) - count);
        end else if (bus_addr >= A_IV0 && bus_addr <= A_IV4) begin
            bus_rdata = iv_q[3'(bus_addr - A_IV0)];
        end else if (bus_addr >= A_DG0 && bus_addr <= A_DG4) begin
            bus_rdata = dig_q[32*int'(bus_addr - A_DG0) +: 32];
            if (bus_addr == A_DG4 && !sha) bus_rdata = '0;
        end
    end

    AST_SEED_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_load |-> dig_q == core_init); // R2
    AST_STOP_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (dig_q == '0 && state == ST_OFF)); // R8
    AST_NO_PUSH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !core_push); // R4

endmodule

// File: tb/hash_regfront_tb.sv
module hash_regfront_tb_top;

    localparam int CLK_NS = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic core_load, core_sha1, core_push, core_done;
    logic [159:0] core_init, core_state;
    logic [511:0] core_block;

    int total = 0, bad = 0, lat = 1;
    bit finished = 0;
    logic [31:0] wbuf [64];
    logic [31:0] ivs [5];

    always #(CLK_NS/2) clk = ~clk;

    hash_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_load(core_load),
        .core_sha1(core_sha1), .core_init(core_init), .core_push(core_push),
        .core_block(core_block), .core_done(core_done), .core_state(core_state)
    );

    function automatic logic [159:0] mix(logic [159:0] s, logic [511:0] b);
        logic [31:0] x = '0;
        logic [159:0] r;
        for (int j = 0; j < 16; j++) x = x ^ (b[j*32 +: 32] + 32'(j));
        for (int i = 0; i < 5; i++)
            r[i*32 +: 32] = {s[i*32 +: 27], s[i*32+27 +: 5]} + x + 32'(i);
        return r;
    endfunction

    function automatic logic [159:0] seed_of(bit sha, bit iva);
        if (iva) return {ivs[4], ivs[3], ivs[2], ivs[1], ivs[0]};
        return {(sha ? 32'hC3D2E1F0 : 32'h0), 32'h10325476, 32'h98BADCFE,
                32'hEFCDAB89, 32'h67452301};
    endfunction

    function automatic logic [159:0] expect_state(bit sha, bit iva, int nblk);
        logic [159:0] s = seed_of(sha, iva);
        logic [511:0] b;
        for (int k = 0; k < nblk; k++) begin
            for (int j = 0; j < 16; j++) b[j*32 +: 32] = wbuf[k*16 + j];
            s = mix(s, b);
        end
        return s;
    endfunction

    // stub compression core
    logic [159:0] st = '0;
    logic [511:0] bq = '0;
    int cnt = 0;
    logic done_q = 1'b0;
    always @(posedge clk) begin
        done_q <= 1'b0;
        if (core_load) st <= core_init;
        if (core_push) begin
            bq  <= core_block;
            cnt <= lat;
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                st     <= mix(st, bq);
                done_q <= 1'b1;
            end
        end
    end
    assign core_done  = done_q;
    assign core_state = st;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic push_words(int first, int n);
        for (int k = 0; k < n; k++) wr(4'd7, wbuf[first + k]);
    endtask

    task automatic chk_digest(string tag, logic [159:0] e, bit sha);
        logic [31:0] v;
        for (int i = 0; i < 5; i++) begin
            rd(4'(8 + i), v);
            chk(tag, v, (i == 4 && !sha) ? 32'h0 : e[i*32 +: 32]);
        end
    endtask

    task automatic wait_end(string tag);
        logic [31:0] v;
        int n = 0;
        do begin
            rd(4'd0, v);
            n++;
        end while (v[3] && n < 3000);
        chk(tag, 32'(v[3]), 32'h0);
    endtask

    task automatic fill_rand(int n);
        for (int k = 0; k < n; k++) wbuf[k] = $urandom;
    endtask

    task automatic session(bit sha, bit iva, int nblk, int npart);
        logic [31:0] v;
        logic [31:0] ctl;
        wr(4'd0, 32'h0);
        for (int i = 0; i < 5; i++) begin
            ivs[i] = $urandom;
            wr(4'(2 + i), ivs[i]);
        end
        ctl = {29'd0, iva, sha, 1'b1};
        wr(4'd0, ctl);
        rd(4'd0, v);             chk("R1 ctl readback", v, ctl);
        chk_digest("R2 seed", seed_of(sha, iva), sha);
        rd(4'd1, v);             chk("R3 free after enable", v, 32'd32);
        fill_rand(nblk * 16 + npart);
        push_words(0, nblk * 16 + npart);
        wr(4'd0, ctl | 32'h8);
        wait_end("R6 data-end clears");
        chk_digest("R4 R5 digest", expect_state(sha, iva, nblk), sha);
        rd(4'd1, v);             chk("R6 leftover discarded", v, 32'd32);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        rd(4'd0, v);  chk("R1 reset ctl", v, 32'h0);
        rd(4'd1, v);  chk("R3 reset status", v, 32'd32);
        rd(4'd8, v);  chk("R8 reset digest", v, 32'h0);

        // queue writes while disabled are ignored (R8)
        wr(4'd7, 32'h1234_5678);
        rd(4'd1, v);  chk("R8 write while off", v, 32'd32);

        // MD5 standard seed, word 4 reads zero (R2, R5)
        lat = 60;
        wr(4'd0, 32'h1);
        rd(4'd12, v); chk("R5 md5 word4", v, 32'h0);
        rd(4'd8, v);  chk("R2 md5 seed w0", v, 32'h67452301);
        rd(4'd11, v); chk("R2 md5 seed w3", v, 32'h10325476);

        // fields other than data-end are frozen while enabled (R1)
        wr(4'd0, 32'h7);
        rd(4'd0, v);  chk("R1 fields frozen", v, 32'h1);

        // free count and block hand-off (R3, R4)
        fill_rand(20);
        push_words(0, 10);
        rd(4'd1, v);  chk("R3 free after 10", v, 32'd22);
        push_words(10, 6);
        @(negedge clk); @(negedge clk);
        rd(4'd1, v);  chk("R4 block popped", v, 32'd32);
        push_words(16, 1);
        rd(4'd1, v);  chk("R3 free after pop+1", v, 32'd31);

        // overflow: core slow, 50 words back to back (R7, R6)
        wr(4'd0, 32'h0);
        wr(4'd0, 32'h3);
        ivs[0] = 0;
        fill_rand(50);
        push_words(0, 50);
        rd(4'd1, v);  chk("R7 overflow full", v, 32'h100);
        wr(4'd0, 32'hB);
        rd(4'd0, v);  chk("R6 data-end held", v, 32'hB);
        wait_end("R6 data-end after overflow");
        chk_digest("R7 dropped words excluded", expect_state(1'b1, 1'b0, 3), 1'b1);
        rd(4'd1, v);  chk("R7 overflow sticky", v, 32'h120);

        // disable wipes everything (R8)
        wr(4'd0, 32'h0);
        rd(4'd0, v);  chk("R8 ctl off", v, 32'h0);
        rd(4'd1, v);  chk("R8 status off", v, 32'd32);
        rd(4'd9, v);  chk("R8 digest off", v, 32'h0);

        // directed corners then random sessions
        lat = 1;
        session(1'b1, 1'b1, 1, 0);
        session(1'b0, 1'b0, 0, 15);
        for (int r = 0; r < 10; r++) begin
            lat = 1 + ($urandom % 8);
            session(1'($urandom), 1'($urandom), int'($urandom % 4), int'($urandom % 16));
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule